// File: doc/BRIEF.md
# Zero-Crossing Phase and Period Meter

This block measures one grid cycle at a time. Two square waves come from comparators that follow the filtered grid voltage and the filtered load current. The block samples both waves on every pulse of a sample-tick strobe. It counts the ticks from one rising edge of the voltage wave to the next, which gives the period. It also counts the ticks from the voltage rising edge to the current rising edge, which gives the phase offset. The sample clock is retuned so that a nominal cycle holds 1600 ticks. One tick therefore equals 1/1600 of a period, or 0.225 degrees, and the tick offset is already the phase in those units.

Each accepted cycle adds one period sample and one phase sample to a four-deep moving average. The averaged period, the averaged phase and a signed trim value are published together with a one-clock valid strobe. The trim value is the averaged period minus 1600, and it steers the external sample-rate generator. A cycle whose length lies outside the window for 49 to 51 Hz is rejected. It raises an error pulse and does not change the published values. When the load current is too small to give a reliable crossing, the phase sample is forced to zero.

Top module: `zc_phase_meter`

## Requirements
- R1: After reset, period_out, phase_out and rate_trim are 0, and valid and range_err are low.
- R2: The input waves are read only on clock edges where tick is 1. Level changes between ticks have no effect. The first voltage rising edge after reset only starts a measurement and produces no output event.
- R3: The period sample is the number of ticks from one voltage rising edge to the next. A voltage rising edge is a tick where volt_sq is 1 and it was 0 at the previous tick.
- R4: The offset d is the number of ticks from the voltage rising edge to the latest current rising edge in the same cycle. A current edge on the same tick as the voltage edge gives d = 0 for the new cycle. The phase sample is d when d < 800, and d − 1600 otherwise. A positive value means the current lags the voltage.
- R5: The phase sample is 0 in two cases: curr_amp is below I_MIN (default 200) on the tick of that current rising edge, or the cycle had no current rising edge.
- R6: A period sample below P_MIN (1568) or above P_MAX (1633) raises range_err for one clock, in the clock after the closing tick. The sample is discarded, and valid and all outputs stay unchanged.
- R7: On an accepted sample, one clock after range_err would have appeared, valid pulses for one clock. At the same time period_out and phase_out take the average of the last 4 accepted samples, rounded toward negative infinity. The outputs change at no other time.
- R8: valid does not assert until 4 samples have been accepted since reset.
- R9: rate_trim is the signed value period_out − 1600. It updates together with period_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-tick strobe, one clock wide |
| volt_sq | input | 1 | Square wave from the grid-voltage comparator |
| curr_sq | input | 1 | Square wave from the load-current comparator |
| curr_amp | input | 12 | Load-current amplitude (default unit mA) |
| period_out | output | 12 | Averaged period in ticks |
| phase_out | output | 12 | Averaged signed phase in 1/1600-period units |
| rate_trim | output | 12 | Signed period error relative to 1600 ticks |
| valid | output | 1 | One-clock strobe when the outputs update |
| range_err | output | 1 | One-clock strobe when a cycle is rejected |

## Verification
A wrong tick counter or offset register shows at the ports as a wrong period_out or phase_out. This appears two clocks after the fourth closing tick at the latest, because every accepted sample enters the average within one cycle. A faulty fill count or accept decision shows as a valid pulse that comes too early or is missing, or as range_err on a legal cycle. Either one appears in the clock right after the tick that closes the cycle. Corruption of the history registers stays visible in the averages for four cycles and is then flushed out.

// File: rtl/zc_phase_meter.sv
module zc_phase_meter #(
  parameter int NOM      = 1600,
  parameter int P_MIN    = 1568,
  parameter int P_MAX    = 1633,
  parameter int CW       = 12,
  parameter int AMP_W    = 12,
  parameter int I_MIN    = 200,
  parameter int AVG_LOG2 = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 volt_sq,
  input  logic                 curr_sq,
  input  logic [AMP_W-1:0]     curr_amp,
  output logic [CW-1:0]        period_out,
  output logic signed [CW-1:0] phase_out,
  output logic signed [CW-1:0] rate_trim,
  output logic                 valid,
  output logic                 range_err
);
  localparam int AVG_N = 1 << AVG_LOG2;
  localparam int SW    = CW + AVG_LOG2;
  localparam int HALF  = NOM / 2;
  localparam int FW    = $clog2(AVG_N + 1);

  logic                 volt_q, curr_q, armed, seen_q, small_q, upd;
  logic [CW-1:0]        ctr, ofs_q;
  logic [FW-1:0]        fill;
  logic [CW-1:0]        hist_p [AVG_N];
  logic signed [CW-1:0] hist_q [AVG_N];

  wire volt_rise = tick & volt_sq & ~volt_q;
  wire curr_rise = tick & curr_sq & ~curr_q;
  wire in_range  = (ctr >= CW'(P_MIN)) && (ctr <= CW'(P_MAX));
  wire accept    = volt_rise & armed & in_range;
  wire reject    = volt_rise & armed & ~in_range;
  wire is_small  = curr_amp < AMP_W'(I_MIN);

  logic signed [CW:0]   ofs_x, ofs_w;
  logic signed [CW-1:0] ph_samp;
  assign ofs_x   = $signed({1'b0, ofs_q});
  assign ofs_w   = (ofs_q < CW'(HALF)) ? ofs_x : ofs_x - (CW+1)'(NOM);
  assign ph_samp = (seen_q && !small_q) ? ofs_w[CW-1:0] : '0;

  logic [SW-1:0]        psum;
  logic signed [SW-1:0] qsum, qavg;
  logic [CW-1:0]        pavg, trim_w;
  always_comb begin
    psum = '0;
    qsum = '0;
    for (int k = 0; k < AVG_N; k++) begin
      psum = psum + SW'(hist_p[k]);
      qsum = qsum + SW'(hist_q[k]);
    end
  end
  assign qavg   = qsum >>> AVG_LOG2;
  assign pavg   = psum[SW-1:AVG_LOG2];
  assign trim_w = pavg - CW'(NOM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      volt_q <= 1'b0;
      curr_q <= 1'b0;
      armed  <= 1'b0;
      ctr    <= '0;
    end else if (tick) begin
      volt_q <= volt_sq;
      curr_q <= curr_sq;
      if (volt_rise) begin
        armed <= 1'b1;
        ctr   <= CW'(1);
      end else if (ctr != '1) begin
        ctr <= ctr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      seen_q  <= 1'b0;
      small_q <= 1'b0;
    end else if (volt_rise) begin
      ofs_q   <= '0;
      seen_q  <= curr_rise;
      small_q <= is_small;
    end else if (curr_rise) begin
      ofs_q   <= ctr;
      seen_q  <= 1'b1;
      small_q <= is_small;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < AVG_N; k++) begin
        hist_p[k] <= '0;
        hist_q[k] <= '0;
      end
      fill      <= '0;
      upd       <= 1'b0;
      range_err <= 1'b0;
    end else begin
      upd       <= accept;
      range_err <= reject;
      if (accept) begin
        for (int k = AVG_N - 1; k > 0; k--) begin
          hist_p[k] <= hist_p[k-1];
          hist_q[k] <= hist_q[k-1];
        end
        hist_p[0] <= ctr;
        hist_q[0] <= ph_samp;
        if (fill != FW'(AVG_N)) fill <= fill + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_out <= '0;
      phase_out  <= '0;
      rate_trim  <= '0;
      valid      <= 1'b0;
    end else begin
      valid <= upd && (fill == FW'(AVG_N));
      if (upd && (fill == FW'(AVG_N))) begin
        period_out <= pavg;
        phase_out  <= qavg[CW-1:0];
        rate_trim  <= $signed(trim_w);
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> (!valid && !range_err && period_out == '0));
  a_r2_err_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> $past(tick));
  a_r4_phase_span: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (phase_out >= -HALF && phase_out < HALF));
  a_r7_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(period_out) |-> valid);
  a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_out) |-> valid);
  a_r8_filled: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> fill == FW'(AVG_N));
  a_r9_trim: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> rate_trim == $signed(period_out - CW'(NOM)));
endmodule

// File: tb/test_zc_phase_meter.sv
module test_zc_phase_meter;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0, volt_sq = 0, curr_sq = 0;
  logic [11:0] curr_amp = 0;
  logic [11:0] period_out;
  logic signed [11:0] phase_out, rate_trim;
  logic valid, range_err;

  zc_phase_meter i_zc_phase_meter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .volt_sq(volt_sq), .curr_sq(curr_sq),
    .curr_amp(curr_amp), .period_out(period_out), .phase_out(phase_out),
    .rate_trim(rate_trim), .valid(valid), .range_err(range_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  int vcnt = 0, ecnt = 0;
  always @(negedge clk) begin
    cycles++;
    if (valid) vcnt++;
    if (range_err) ecnt++;
  end

  int mp[4], mq[4];
  int mfill = 0;
  int exp_po = 0, exp_ph = 0, exp_tr = 0;
  bit have_prev = 0, prev_glitch = 0;
  int prev_p, prev_d, prev_amp;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fdiv4(int s);
    return (s >= 0) ? s / 4 : -((-s + 3) / 4);
  endfunction

  task automatic close_and_check(int v0, int e0);
    bit inr, forced;
    int ph, ps, qs;
    if (!have_prev) begin
      check(vcnt == v0 && ecnt == e0, "R2", vcnt - v0 + ecnt - e0, 0);
    end else begin
      inr = prev_p >= 1568 && prev_p <= 1633;
      forced = (prev_d < 0) || (prev_amp < 200);
      ph = forced ? 0 : ((prev_d < 800) ? prev_d : prev_d - 1600);
      if (inr) begin
        for (int k = 3; k > 0; k--) begin mp[k] = mp[k-1]; mq[k] = mq[k-1]; end
        mp[0] = prev_p; mq[0] = ph;
        if (mfill < 4) mfill++;
        check(ecnt == e0, "R6", ecnt - e0, 0);
        if (mfill == 4) begin
          ps = mp[0] + mp[1] + mp[2] + mp[3];
          qs = mq[0] + mq[1] + mq[2] + mq[3];
          exp_po = ps / 4; exp_ph = fdiv4(qs); exp_tr = exp_po - 1600;
          check(vcnt == v0 + 1, "R7", vcnt - v0, 1);
        end else begin
          check(vcnt == v0, "R8", vcnt - v0, 0);
        end
      end else begin
        check(ecnt == e0 + 1, "R6", ecnt - e0, 1);
        check(vcnt == v0, "R6", vcnt - v0, 0);
      end
      check(int'(period_out) == exp_po, prev_glitch ? "R2" : "R3", int'(period_out), exp_po);
      check(int'(phase_out) == exp_ph, forced ? "R5" : "R4", int'(phase_out), exp_ph);
      check(int'(rate_trim) == exp_tr, "R9", int'(rate_trim), exp_tr);
    end
  endtask

  task automatic run_period(int p, int d, int amp, bit glitch);
    int v0, e0;
    curr_amp = 12'(amp);
    for (int t = 0; t < p; t++) begin
      @(negedge clk);
      volt_sq = (t < p / 2);
      curr_sq = (d >= 0) && (t >= d) && (t < d + 200) && (t < p - 1);
      tick = 1;
      if (t == 0) begin v0 = vcnt; e0 = ecnt; end
      @(negedge clk);
      tick = 0;
      if (glitch && t == p / 2 + 5) begin
        volt_sq = 1;
        @(negedge clk);
        volt_sq = 0;
      end
      if (t == 0) begin
        @(negedge clk);
        #1;
        close_and_check(v0, e0);
      end
    end
    prev_p = p; prev_d = d; prev_amp = amp; prev_glitch = glitch; have_prev = 1;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(period_out == 0 && phase_out == 0 && rate_trim == 0, "R1", int'(period_out), 0);
    check(!valid && !range_err, "R1", int'(valid) + int'(range_err), 0);
  endtask

  task automatic t_warmup;
    for (int n = 0; n < 6; n++) run_period(1600, 100, 500, 0);
  endtask

  task automatic t_lead_lag;
    run_period(1590, 1000, 500, 0);
    run_period(1610, 0, 500, 0);
    run_period(1600, 799, 500, 0);
    run_period(1620, 800, 500, 0);
    run_period(1580, 1500, 500, 0);
    run_period(1600, 3, 500, 0);
  endtask

  task automatic t_small_current;
    run_period(1600, 300, 150, 0);
    run_period(1600, -1, 500, 0);
    run_period(1600, 400, 200, 0);
    run_period(1600, 600, 199, 0);
  endtask

  task automatic t_range;
    run_period(1567, 50, 500, 0);
    run_period(1634, 50, 500, 0);
    run_period(1568, 60, 500, 0);
    run_period(1633, 70, 500, 0);
    run_period(1700, 70, 500, 0);
  endtask

  task automatic t_glitch;
    run_period(1600, 200, 500, 1);
    run_period(1600, 200, 500, 1);
    run_period(1600, 200, 500, 0);
  endtask

  initial begin
    t_reset;
    t_warmup;
    t_lead_lag;
    t_small_current;
    t_range;
    t_glitch;
    run_period(1600, 100, 500, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule